// File: doc/BRIEF.md
# Quad-Bank Outbound Staging Buffer

This block collects outbound bytes from the merged transmit endpoints and holds them for the host link. Storage is split into four equal banks of 512 bytes (2048 bytes in all). Banks are filled one after another. A bank that becomes full is handed over to the drain side as a whole, and writing moves on to the next bank. A flush request hands over a partly filled bank together with its byte count, so that a short transfer can complete without waiting for 512 bytes.

The drain side reads the oldest handed-over bank one byte per clock under a ready/valid handshake. A marker flags the final byte of each bank. Once that byte is taken, the bank is free again. A registered back-pressure flag tells the endpoints to stop sending. It rises one byte before the storage is full, so one byte already in flight is still taken in. It drops in the cycle after the oldest bank is freed.

Top module: `qbank_tx_stage`

## Requirements
- R1: After reset, `rd_valid_o` and `full_o` are low, all banks are empty, and the first bank handed over after reset is the first one drained.
- R2: When the 512th byte is written into the current bank, that bank is handed over without a flush. Its 512 bytes are drained in write order, and `rd_last_o` is high only on the 512th byte.
- R3: A flush (`flush_i` high) hands over the current bank if it holds at least one byte. A byte written in the same cycle as the flush is included. The drain then delivers exactly that many bytes, with `rd_last_o` high on the final one.
- R4: A flush while the current bank is empty has no effect: no bank becomes drainable.
- R5: Banks are used in the strict cyclic order 0, 1, 2, 3, 0, and they are drained in the same order in which they were handed over.
- R6: A byte leaves the drain side only in a cycle where `rd_valid_o` and `rd_ready_i` are both high. While `rd_valid_o` is high and `rd_ready_i` is low, `rd_data_o` and `rd_last_o` hold their values.
- R7: Occupancy counts 512 for each handed-over bank plus the bytes in the bank being written. `full_o` is a register. It is high in the cycle after occupancy reaches 2047 and stays high while occupancy is 2047 or more.
- R8: With `full_o` high, one more byte is still accepted (occupancy 2048). Writes made while all four banks are handed over are dropped and never drained.
- R9: `full_o` falls in the cycle after the final byte of the oldest bank is drained, provided that this brings occupancy below 2047.
- R10: `rd_valid_o` is low whenever no handed-over bank remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write one byte this cycle |
| wr_data_i | input | 8 | Byte to stage |
| flush_i | input | 1 | Hand over the partly filled current bank |
| full_o | output | 1 | Registered back-pressure toward the endpoints |
| rd_valid_o | output | 1 | Drain byte available |
| rd_ready_i | input | 1 | Drain side takes the byte this cycle |
| rd_data_o | output | 8 | Byte at the head of the oldest bank |
| rd_last_o | output | 1 | Current drain byte is the final byte of its bank |

## Verification
A write or flush at clock edge N is visible on the drain outputs and on `full_o` in the cycle after edge N. The drain outputs follow from state with no further register stage, so a drained byte advances the head at the same edge that takes it. The bench drives its inputs on the falling edge and samples at the next falling edge. Each check therefore sees the state after exactly one rising edge for each stimulus. For the back-pressure checks, the bench stops the write or drain stream at the exact byte count where `full_o` should change (2046, 2047, 2048 written; 511 and 512 drained) and samples right after that byte's edge.

// File: rtl/qbs_pkg.sv
package qbs_pkg;
  localparam int unsigned QBS_DATA_W     = 8;
  localparam int unsigned QBS_BANK_DEPTH = 512;
  localparam int unsigned QBS_NUM_BANKS  = 4;
endpackage

// File: rtl/qbs_wr_ctrl.sv
module qbs_wr_ctrl #(
  parameter  int unsigned NUM_BANKS  = 4,
  parameter  int unsigned BANK_DEPTH = 512,
  localparam int unsigned PTR_W      = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W      = $clog2(BANK_DEPTH),
  localparam int unsigned CNT_W      = $clog2(BANK_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             flush_i,
  input  logic             room_i,
  output logic             wr_fire_o,
  output logic [PTR_W-1:0] wr_bank_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             commit_o,
  output logic [CNT_W-1:0] commit_len_o,
  output logic [CNT_W-1:0] fill_o,
  output logic [CNT_W-1:0] fill_nxt_o
);
  logic [PTR_W-1:0] bank_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;

  assign wr_fire_o    = wr_valid_i & room_i;
  assign cnt_inc      = cnt_q + CNT_W'(wr_fire_o);
  // full bank commits itself; flush commits any non-empty bank
  assign commit_o     = room_i & ((cnt_inc == CNT_W'(BANK_DEPTH)) |
                                  (flush_i & (cnt_inc != '0)));
  assign commit_len_o = cnt_inc;
  assign wr_bank_o    = bank_q;
  assign wr_idx_o     = cnt_q[IDX_W-1:0];
  assign fill_o       = cnt_q;
  assign fill_nxt_o   = commit_o ? '0 : cnt_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= fill_nxt_o;
      if (commit_o)
        bank_q <= (bank_q == PTR_W'(NUM_BANKS - 1)) ? '0 : bank_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/qbs_store.sv
module qbs_store #(
  parameter  int unsigned DATA_W = 8,
  parameter  int unsigned DEPTH  = 2048,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/qbs_rd_ctrl.sv
module qbs_rd_ctrl #(
  parameter  int unsigned NUM_BANKS  = 4,
  parameter  int unsigned BANK_DEPTH = 512,
  localparam int unsigned PTR_W      = $clog2(NUM_BANKS),
  localparam int unsigned IDX_W      = $clog2(BANK_DEPTH),
  localparam int unsigned CNT_W      = $clog2(BANK_DEPTH + 1),
  localparam int unsigned NC_W       = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [PTR_W-1:0] commit_bank_i,
  input  logic [CNT_W-1:0] commit_len_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic             rd_last_o,
  output logic [PTR_W-1:0] rd_bank_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             release_o,
  output logic [NC_W-1:0]  n_comm_o,
  output logic [NC_W-1:0]  n_comm_nxt_o
);
  logic [CNT_W-1:0] len_q [NUM_BANKS];
  logic [PTR_W-1:0] bank_q;
  logic [IDX_W-1:0] idx_q;
  logic [NC_W-1:0]  n_q;
  logic [CNT_W-1:0] cur_len;
  logic             fire;

  assign cur_len      = len_q[bank_q];
  assign rd_valid_o   = (n_q != '0);
  assign rd_last_o    = rd_valid_o & ((CNT_W'(idx_q) + CNT_W'(1)) == cur_len);
  assign fire         = rd_valid_o & rd_ready_i;
  assign release_o    = fire & rd_last_o;
  assign rd_bank_o    = bank_q;
  assign rd_idx_o     = idx_q;
  assign n_comm_o     = n_q;
  assign n_comm_nxt_o = n_q + NC_W'(commit_i) - NC_W'(release_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) len_q[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++)
        if (commit_i && (commit_bank_i == PTR_W'(b))) len_q[b] <= commit_len_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      idx_q  <= '0;
      n_q    <= '0;
    end else begin
      n_q <= n_comm_nxt_o;
      if (fire) begin
        if (rd_last_o) begin
          idx_q  <= '0;
          bank_q <= (bank_q == PTR_W'(NUM_BANKS - 1)) ? '0 : bank_q + PTR_W'(1);
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/qbank_tx_stage.sv
module qbank_tx_stage
  import qbs_pkg::*;
#(
  parameter int unsigned DATA_W     = QBS_DATA_W,
  parameter int unsigned BANK_DEPTH = QBS_BANK_DEPTH,
  parameter int unsigned NUM_BANKS  = QBS_NUM_BANKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              flush_i,
  output logic              full_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_last_o
);
  localparam int unsigned CAP   = NUM_BANKS * BANK_DEPTH;
  localparam int unsigned AW    = $clog2(CAP);
  localparam int unsigned PTR_W = $clog2(NUM_BANKS);
  localparam int unsigned IDX_W = $clog2(BANK_DEPTH);
  localparam int unsigned CNT_W = $clog2(BANK_DEPTH + 1);
  localparam int unsigned NC_W  = $clog2(NUM_BANKS + 1);
  localparam int unsigned OCC_W = $clog2(CAP + 1);

  logic             wr_fire, commit, rel, room;
  logic [PTR_W-1:0] wr_bank, rd_bank;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [CNT_W-1:0] commit_len, fill, fill_nxt;
  logic [NC_W-1:0]  n_comm, n_comm_nxt;
  logic [OCC_W-1:0] occ, occ_nxt;
  logic             full_q;

  assign room = (n_comm != NC_W'(NUM_BANKS));

  qbs_wr_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH)) u_wr (
    .clk_i, .rst_ni, .wr_valid_i, .flush_i,
    .room_i       (room),
    .wr_fire_o    (wr_fire),
    .wr_bank_o    (wr_bank),
    .wr_idx_o     (wr_idx),
    .commit_o     (commit),
    .commit_len_o (commit_len),
    .fill_o       (fill),
    .fill_nxt_o   (fill_nxt)
  );

  qbs_rd_ctrl #(.NUM_BANKS(NUM_BANKS), .BANK_DEPTH(BANK_DEPTH)) u_rd (
    .clk_i, .rst_ni,
    .commit_i      (commit),
    .commit_bank_i (wr_bank),
    .commit_len_i  (commit_len),
    .rd_ready_i,
    .rd_valid_o,
    .rd_last_o,
    .rd_bank_o     (rd_bank),
    .rd_idx_o      (rd_idx),
    .release_o     (rel),
    .n_comm_o      (n_comm),
    .n_comm_nxt_o  (n_comm_nxt)
  );

  qbs_store #(.DATA_W(DATA_W), .DEPTH(CAP)) u_mem (
    .clk_i,
    .we_i    (wr_fire),
    .waddr_i ({wr_bank, wr_idx}),
    .wdata_i (wr_data_i),
    .raddr_i ({rd_bank, rd_idx}),
    .rdata_o (rd_data_o)
  );

  // committed banks count whole, even when flushed short
  assign occ     = OCC_W'(n_comm) * OCC_W'(BANK_DEPTH) + OCC_W'(fill);
  assign occ_nxt = OCC_W'(n_comm_nxt) * OCC_W'(BANK_DEPTH) + OCC_W'(fill_nxt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= (occ_nxt >= OCC_W'(CAP - 1));
  end

  assign full_o = full_q;
endmodule

// File: rtl/qbank_tx_stage_chk.sv
module qbank_tx_stage_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OCC_W  = 12,
  parameter int unsigned NC_W   = 3,
  parameter int unsigned CAP    = 2048
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              full_o,
  input logic              rd_valid_o,
  input logic              rd_ready_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_last_o,
  input logic              wr_fire,
  input logic              commit,
  input logic              rel,
  input logic [OCC_W-1:0]  occ,
  input logic [NC_W-1:0]   n_comm
);
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= OCC_W'(CAP)); // R8
  AST_FULL_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(wr_fire || commit)); // R7
  AST_FULL_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(rel)); // R9
  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel && (n_comm == NC_W'(1)) && !commit |=> !rd_valid_o); // R10
endmodule

bind qbank_tx_stage qbank_tx_stage_chk #(
  .DATA_W(DATA_W), .OCC_W(OCC_W), .NC_W(NC_W), .CAP(CAP)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .full_o(full_o), .rd_valid_o(rd_valid_o),
  .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o), .rd_last_o(rd_last_o),
  .wr_fire(wr_fire), .commit(commit), .rel(rel), .occ(occ), .n_comm(n_comm)
);

// File: tb/sim_qbank_tx_stage.sv
module sim_qbank_tx_stage;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct packed {
    logic [11:0] len;
    logic        flush_last;
    logic        stall;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{12'd1,   1'b1, 1'b0},
    '{12'd5,   1'b0, 1'b1},
    '{12'd300, 1'b1, 1'b0},
    '{12'd511, 1'b0, 1'b1},
    '{12'd512, 1'b0, 1'b0},
    '{12'd2,   1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       flush_i = 1'b0;
  logic       rd_ready_i = 1'b0;
  logic       full_o, rd_valid_o, rd_last_o;
  logic [7:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  qbank_tx_stage u0 (
    .clk_i(clk), .rst_ni, .wr_valid_i, .wr_data_i, .flush_i,
    .full_o, .rd_valid_o, .rd_ready_i, .rd_data_o, .rd_last_o
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i) ^ {i[10:9], 6'b0};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_valid_i = 1'b0; flush_i = 1'b0; rd_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_run(int base, int n, bit flush_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid_i = 1'b1;
      wr_data_i  = pat(base + i);
      flush_i    = flush_last && (i == n - 1);
    end
    @(negedge clk);
    wr_valid_i = 1'b0;
    flush_i    = 1'b0;
  endtask

  task automatic flush_pulse();
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
  endtask

  task automatic drain_run(string req, int base, int k0, int cnt, int len, bit stall);
    int k = k0;
    int cyc = 0;
    while (k < k0 + cnt) begin
      @(negedge clk);
      rd_ready_i = 1'b0;
      check(req, "rd_valid", int'(rd_valid_o), 1);
      check(req, "rd_data", int'(rd_data_o), int'(pat(base + k)));
      if (stall && (cyc % 3 == 1)) begin
        check("R6", "stalled rd_last", int'(rd_last_o), int'(k == len - 1));
      end else begin
        check(req, "rd_last", int'(rd_last_o), int'(k == len - 1));
        rd_ready_i = 1'b1;
        k++;
      end
      cyc++;
    end
    @(negedge clk);
    rd_ready_i = 1'b0;
  endtask

  initial begin
    int base;
    do_reset();
    check("R1", "rd_valid after reset", int'(rd_valid_o), 0);
    check("R1", "full after reset", int'(full_o), 0);
    // R4: flush on empty bank does nothing
    flush_pulse();
    @(negedge clk);
    check("R4", "rd_valid after empty flush", int'(rd_valid_o), 0);

    // vector table: R2 R3 R5 R6 R10
    base = 0;
    foreach (VEC[v]) begin
      write_run(base, int'(VEC[v].len), VEC[v].flush_last);
      if (!VEC[v].flush_last) flush_pulse();
      drain_run(VEC[v].len == 12'd512 ? "R2" : "R3", base, 0, int'(VEC[v].len),
                int'(VEC[v].len), VEC[v].stall);
      check("R10", "rd_valid after drain", int'(rd_valid_o), 0);
      base += int'(VEC[v].len);
    end

    // back-pressure: R7 R8 R9, order R5
    do_reset();
    write_run(0, 2046, 1'b0);
    check("R7", "full at 2046", int'(full_o), 0);
    write_run(2046, 1, 1'b0);
    check("R7", "full at 2047", int'(full_o), 1);
    write_run(2047, 1, 1'b0);
    check("R8", "full at 2048", int'(full_o), 1);
    @(negedge clk); wr_valid_i = 1'b1; wr_data_i = 8'hEE;
    @(negedge clk); wr_valid_i = 1'b0;
    flush_pulse();
    check("R8", "full after dropped write", int'(full_o), 1);
    drain_run("R5", 0, 0, 511, 512, 1'b0);
    check("R9", "full before bank freed", int'(full_o), 1);
    drain_run("R5", 0, 511, 1, 512, 1'b0);
    check("R9", "full after bank freed", int'(full_o), 0);
    for (int b = 1; b < 4; b++) drain_run("R5", 512 * b, 0, 512, 512, b == 2);
    check("R8", "dropped byte never drained", int'(rd_valid_o), 0);
    // wraps back to bank 0 after release
    write_run(7, 3, 1'b1);
    drain_run("R5", 7, 0, 3, 3, 1'b0);
    check("R10", "rd_valid after wrap drain", int'(rd_valid_o), 0);

    // R1: reset mid-operation discards staged banks
    write_run(40, 10, 1'b1);
    check("R3", "rd_valid before reset", int'(rd_valid_o), 1);
    do_reset();
    check("R1", "rd_valid after mid reset", int'(rd_valid_o), 0);
    check("R1", "full after mid reset", int'(full_o), 0);
    write_run(100, 4, 1'b1);
    drain_run("R1", 100, 0, 4, 4, 1'b0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule